// File: doc/BRIEF.md
# Framed Serial DAC Control Interface

This block is the digital front end of a single-channel voltage-output DAC. A host writes to it over a write-only three-wire link: an active-low frame select, a serial clock and a data line. Every pin is oversampled on a fast system clock. Each pin passes through a synchronizer, and the clock and frame select edges are found in the system clock domain. Bits are collected most significant first on falling serial-clock edges. When exactly one frame's worth of edges has arrived, the frame is turned into a converter code and a two-bit output mode.

The block is parameterized for a 12-, 14- or 16-bit converter. The 12- and 14-bit builds use a 16-bit frame and the 16-bit build uses a 24-bit frame. The outputs are:
- the held code;
- the current mode;
- four decoded output-stage selects, of which exactly one is active;
- a one-cycle strobe that marks each commit.

The analog converter, the amplifier and the termination resistors sit outside the block and are driven by these outputs.

Top module: `serdac_frame_rx`

## Requirements
- R1: After reset, and whenever reset is asserted even in the middle of a frame, the code is all zeros, the mode is 00, the drive select is high and the update strobe is low.
- R2: A frame commits on its final falling serial-clock edge, the 16th for the 12/14-bit builds and the 24th for the 16-bit build. The update strobe is high for exactly one system cycle, and that is the same cycle in which the new code and mode first appear. No other cycle changes the code or the mode.
- R3: Bits arrive most significant first. In the committed word, the code occupies bits DAC_BITS-1:0 and the mode occupies bits DAC_BITS+1:DAC_BITS. This gives bits 13:12 for 12-bit, 15:14 for 14-bit and 17:16 for 16-bit. Any higher frame bits are ignored.
- R4: If frame select rises before the final falling edge, the frame is dropped: code and mode keep their values and no strobe is issued.
- R5: The mode decodes to exactly one select: 00 gives drive, 01 gives a 1 kΩ termination to ground, 10 gives a 100 kΩ termination to ground, and 11 gives high impedance.
- R6: A committed frame with a nonzero mode changes the mode but keeps the held code. A later frame with mode 00 loads its own code.
- R7: Falling serial-clock edges after a full frame are ignored until frame select has gone high and then low again.
- R8: If frame select rises in the same system cycle in which the final falling edge is detected, the abort wins and nothing is committed.
- R9: Serial-clock activity while frame select is high has no effect, and the serial clock may idle either high or low before a frame opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data, most significant bit first |
| code_o | output | DAC_BITS | Held converter code |
| mode_o | output | 2 | Current output mode |
| drive_en_o | output | 1 | Amplifier drives the output (mode 00) |
| term_1k_o | output | 1 | Output tied to ground through about 1 kΩ (mode 01) |
| term_100k_o | output | 1 | Output tied to ground through about 100 kΩ (mode 10) |
| term_hiz_o | output | 1 | Output left high impedance (mode 11) |
| upd_o | output | 1 | One-cycle commit strobe |

## Verification
Two functions can fall in the same system cycle: detection of the final falling serial-clock edge, which commits the frame, and detection of frame select going high, which aborts it. The bench makes them collide by driving both pins on the same clock edge. Both pins pass through synchronizers of equal depth, so the two events are seen in one cycle. The 24-bit build must then keep its code, mode and strobe count unchanged. The 12-bit build on the same wires, which already completed its 16-bit frame earlier in that transfer, must commit normally.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_SHIFT = 2'd1,
      RX_FULL  = 2'd2
   } rx_state_e;

   typedef enum logic [1:0] {
      PD_DRIVE    = 2'b00,
      PD_GND_LOW  = 2'b01,
      PD_GND_HIGH = 2'b10,
      PD_FLOAT    = 2'b11
   } pd_mode_e;

   localparam int MODE_W = 2;

   // Frame length is tied to converter width: wide builds need the long frame.
   function automatic int frame_bits(input int dac_bits);
      return (dac_bits > 14) ? 24 : 16;
   endfunction

endpackage

// File: rtl/serdac_sync2.sv
module serdac_sync2 #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] lvl_o
);

   initial begin
      assert (STAGES >= 2) else $error("serdac_sync2: STAGES must be 2 or more");
      assert (W >= 1)      else $error("serdac_sync2: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= pin_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign lvl_o = stg[STAGES-1];

endmodule

// File: rtl/serdac_shift.sv
module serdac_shift
   import serdac_pkg::*;
#(
   parameter int DAC_BITS = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_s_i,   // synchronized frame select (active low)
   input  logic                   sck_s_i,   // synchronized serial clock
   input  logic                   sdi_s_i,   // synchronized serial data
   output logic [DAC_BITS+1:0]    word_o,    // mode + code as received
   output logic                   done_o     // one cycle, frame complete
);

   localparam int FRAME_LEN = frame_bits(DAC_BITS);
   localparam int KEEP      = DAC_BITS + MODE_W;
   localparam int CW        = $clog2(FRAME_LEN);
   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   initial begin
      assert (FRAME_LEN >= KEEP) else $error("serdac_shift: frame too short for width");
   end

   rx_state_e      st;
   logic [CW-1:0]  cnt;
   logic [KEEP-1:0] sr;
   logic           frm_q;
   logic           sck_q;
   logic           frm_fall;
   logic           sck_fall;

   assign frm_fall = frm_q  & ~frm_s_i;
   assign sck_fall = sck_q  & ~sck_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         sr     <= '0;
         frm_q  <= 1'b1;
         sck_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         frm_q  <= frm_s_i;
         sck_q  <= sck_s_i;
         done_o <= 1'b0;
         if (frm_s_i) begin
            // select high: abort has priority over any edge in this cycle
            st  <= RX_IDLE;
            cnt <= '0;
         end else begin
            unique case (st)
               RX_IDLE: begin
                  cnt <= '0;
                  if (frm_fall) st <= RX_SHIFT;
               end
               RX_SHIFT: begin
                  if (sck_fall) begin
                     sr <= {sr[KEEP-2:0], sdi_s_i};
                     if (cnt == LAST) begin
                        st     <= RX_FULL;
                        done_o <= 1'b1;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               RX_FULL: st <= RX_FULL;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign word_o = sr;

   // R4 / R8: a high select always returns the receiver to idle
   a_r4_select_high_idles: assert property (@(posedge clk) disable iff (!rst_n)
      frm_s_i |=> (st == RX_IDLE));

   // R7: once full, the receiver stays full while select is low
   a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_FULL && !frm_s_i) |=> (st == RX_FULL && !done_o));

   // R2: completion is reported only from a frame that was shifting
   a_r2_done_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(st) == RX_SHIFT && st == RX_FULL));

endmodule

// File: rtl/serdac_hold.sv
module serdac_hold
   import serdac_pkg::*;
#(
   parameter int DAC_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DAC_BITS+1:0]  word_i,
   input  logic                 done_i,
   output logic [DAC_BITS-1:0]  code_o,
   output logic [MODE_W-1:0]    mode_o,
   output logic                 drive_en_o,
   output logic                 term_1k_o,
   output logic                 term_100k_o,
   output logic                 term_hiz_o,
   output logic                 upd_o
);

   localparam int PD_LSB = DAC_BITS;

   pd_mode_e            mode_q;
   pd_mode_e            mode_new;
   logic [DAC_BITS-1:0] code_q;
   logic                upd_q;

   assign mode_new = pd_mode_e'(word_i[PD_LSB +: MODE_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PD_DRIVE;
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= done_i;
         if (done_i) begin
            mode_q <= mode_new;
            if (mode_new == PD_DRIVE) code_q <= word_i[DAC_BITS-1:0];
         end
      end
   end

   // One select per mode value, built from a loop over the four encodings.
   logic [3:0] sel;
   for (genvar m = 0; m < 4; m++) begin : g_sel
      assign sel[m] = (mode_q == pd_mode_e'(m));
   end

   assign drive_en_o  = sel[PD_DRIVE];
   assign term_1k_o   = sel[PD_GND_LOW];
   assign term_100k_o = sel[PD_GND_HIGH];
   assign term_hiz_o  = sel[PD_FLOAT];
   assign code_o      = code_q;
   assign mode_o      = mode_q;
   assign upd_o       = upd_q;

   // R2: code and mode move only in a strobe cycle
   a_r2_code_moves_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> upd_o);
   a_r2_mode_moves_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_o) |-> upd_o);

   // R2: the strobe lasts a single cycle
   a_r2_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);

   // R6: a power-down commit keeps the held code
   a_r6_code_kept_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && mode_o != PD_DRIVE) |-> $stable(code_o));

   // R5: exactly one output-stage select at a time
   a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({drive_en_o, term_1k_o, term_100k_o, term_hiz_o}) == 1);

endmodule

// File: rtl/serdac_frame_rx.sv
module serdac_frame_rx
   import serdac_pkg::*;
#(
   parameter int DAC_BITS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_n_i,
   input  logic                 sclk_i,
   input  logic                 sdin_i,
   output logic [DAC_BITS-1:0]  code_o,
   output logic [1:0]           mode_o,
   output logic                 drive_en_o,
   output logic                 term_1k_o,
   output logic                 term_100k_o,
   output logic                 term_hiz_o,
   output logic                 upd_o
);

   initial begin
      assert (DAC_BITS == 12 || DAC_BITS == 14 || DAC_BITS == 16)
         else $error("serdac_frame_rx: DAC_BITS must be 12, 14 or 16");
   end

   // pin order inside the synchronizer: {frame, sclk, data}; frame idles high
   localparam logic [2:0] PIN_RST = 3'b100;

   logic [2:0]           pins_s;
   logic [DAC_BITS+1:0]  word;
   logic                 done;

   serdac_sync2 #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i ({frame_n_i, sclk_i, sdin_i}),
      .lvl_o (pins_s)
   );

   serdac_shift #(
      .DAC_BITS (DAC_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .frm_s_i (pins_s[2]),
      .sck_s_i (pins_s[1]),
      .sdi_s_i (pins_s[0]),
      .word_o  (word),
      .done_o  (done)
   );

   serdac_hold #(
      .DAC_BITS (DAC_BITS)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_i      (word),
      .done_i      (done),
      .code_o      (code_o),
      .mode_o      (mode_o),
      .drive_en_o  (drive_en_o),
      .term_1k_o   (term_1k_o),
      .term_100k_o (term_100k_o),
      .term_hiz_o  (term_hiz_o),
      .upd_o       (upd_o)
   );

   // R1: coming out of reset the outputs sit at zero code, driving
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (code_o == '0 && mode_o == 2'b00 && !upd_o));

endmodule

// File: tb/sim_serdac_frame_rx.sv
`timescale 1ns/1ps
module sim_serdac_frame_rx;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1;
   logic sclk = 1'b0;
   logic sdin = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   logic [15:0] c0;  logic [1:0] m0;  logic d0, k0, h0, z0, u0_upd;
   logic [11:0] c1;  logic [1:0] m1;  logic d1, k1, h1, z1, u1_upd;

   serdac_frame_rx #(.DAC_BITS(16)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk), .sdin_i(sdin),
      .code_o(c0), .mode_o(m0), .drive_en_o(d0), .term_1k_o(k0),
      .term_100k_o(h0), .term_hiz_o(z0), .upd_o(u0_upd));

   serdac_frame_rx #(.DAC_BITS(12)) u1 (
      .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk), .sdin_i(sdin),
      .code_o(c1), .mode_o(m1), .drive_en_o(d1), .term_1k_o(k1),
      .term_100k_o(h1), .term_hiz_o(z1), .upd_o(u1_upd));

   int n_tests = 0;
   int n_fail  = 0;
   int upd0_cnt = 0;
   int upd1_cnt = 0;
   bit finished = 1'b0;

   logic [15:0] e0_code = '0;  logic [1:0] e0_mode = '0;  int e0_upd = 0;
   logic [11:0] e1_code = '0;  logic [1:0] e1_mode = '0;  int e1_upd = 0;

   always @(negedge clk) begin
      if (u0_upd) upd0_cnt++;
      if (u1_upd) upd1_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] sel_of(input logic [1:0] m);
      return 4'b1000 >> m;   // {drive, 1k, 100k, hiz}
   endfunction

   // vector: {idle_hi, race, n[4:0], bits[31:0]}
   localparam int NV = 12;
   localparam logic [38:0] VECS [NV] = '{
      {1'b0, 1'b0, 5'd24, 32'h00FC_BEEF},
      {1'b0, 1'b0, 5'd24, 32'h0001_1111},
      {1'b1, 1'b0, 5'd24, 32'h0002_2222},
      {1'b0, 1'b0, 5'd24, 32'h0003_3333},
      {1'b1, 1'b0, 5'd24, 32'h0000_7E81},
      {1'b0, 1'b0, 5'd24, 32'h0015_5AAA},
      {1'b0, 1'b0, 5'd24, 32'h002A_0F0F},
      {1'b0, 1'b0, 5'd10, 32'h0000_03FF},
      {1'b1, 1'b0, 5'd20, 32'h000A_BCDE},
      {1'b0, 1'b1, 5'd24, 32'h0000_1357},
      {1'b0, 1'b0, 5'd28, 32'h000A_BCDF},
      {1'b0, 1'b0, 5'd23, 32'h007F_FFFF}
   };

   task automatic send_frame(input logic [31:0] bits, input int n, input bit race, input bit idle_hi);
      sclk = idle_hi;
      repeat (4) @(negedge clk);
      frame_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b1;
         sdin = bits[i];
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         if (race && i == 0) frame_n = 1'b1;
         repeat (4) @(negedge clk);
      end
      frame_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   // expected values from the requirements (R2, R3, R6)
   task automatic model(input logic [31:0] bits, input int n, input bit race);
      int eff;
      logic [31:0] w;
      eff = race ? n - 1 : n;
      if (eff >= 24) begin
         w = bits >> (n - 24);
         e0_mode = w[17:16];
         if (w[17:16] == 2'b00) e0_code = w[15:0];
         e0_upd++;
      end
      if (eff >= 16) begin
         w = bits >> (n - 16);
         e1_mode = w[13:12];
         if (w[13:12] == 2'b00) e1_code = w[11:0];
         e1_upd++;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held at reset values while reset is low
      chk("R1 code under reset", 32'(c0), 32'h0);
      chk("R1 strobe under reset", 32'(u0_upd), 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 code after reset", 32'(c0), 32'h0);
      chk("R1 mode after reset", 32'(m0), 32'h0);
      chk("R1 selects after reset", 32'({d0, k0, h0, z0}), 32'h8);
      chk("R1 12-bit code after reset", 32'(c1), 32'h0);

      for (int v = 0; v < NV; v++) begin
         logic [31:0] bits;
         int n;
         bit race, idle_hi;
         string t0, t1;
         bits    = VECS[v][31:0];
         n       = int'(VECS[v][36:32]);
         race    = VECS[v][37];
         idle_hi = VECS[v][38];
         send_frame(bits, n, race, idle_hi);
         model(bits, n, race);
         if (race)        t0 = "R8";
         else if (n < 24) t0 = "R4";
         else if (n > 24) t0 = "R7";
         else if (e0_mode != 2'b00) t0 = "R6";
         else             t0 = "R3";
         t1 = (n < 16) ? "R4" : "R7";
         chk($sformatf("%s u0 code vec %0d", t0, v), 32'(c0), 32'(e0_code));
         chk($sformatf("%s u0 mode vec %0d", t0, v), 32'(m0), 32'(e0_mode));
         chk($sformatf("R5 u0 selects vec %0d", v), 32'({d0, k0, h0, z0}), 32'(sel_of(e0_mode)));
         chk($sformatf("R2 u0 strobes vec %0d", v), 32'(upd0_cnt), 32'(e0_upd));
         chk($sformatf("%s u1 code vec %0d", t1, v), 32'(c1), 32'(e1_code));
         chk($sformatf("%s u1 mode vec %0d", t1, v), 32'(m1), 32'(e1_mode));
         chk($sformatf("R5 u1 selects vec %0d", v), 32'({d1, k1, h1, z1}), 32'(sel_of(e1_mode)));
         chk($sformatf("R2 u1 strobes vec %0d", v), 32'(upd1_cnt), 32'(e1_upd));
      end

      // R9: serial clock and data toggling while select is high
      for (int i = 0; i < 30; i++) begin
         sclk = ~sclk;
         sdin = i[0];
         repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R9 code unchanged", 32'(c0), 32'(e0_code));
      chk("R9 mode unchanged", 32'(m0), 32'(e0_mode));
      chk("R9 no strobe", 32'(upd0_cnt), 32'(e0_upd));
      chk("R9 12-bit no strobe", 32'(upd1_cnt), 32'(e1_upd));

      // R1: reset in the middle of a frame
      sclk = 1'b0;
      frame_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         sclk = 1'b1; sdin = 1'b1; repeat (4) @(negedge clk);
         sclk = 1'b0;              repeat (4) @(negedge clk);
      end
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 code after mid-frame reset", 32'(c0), 32'h0);
      chk("R1 mode after mid-frame reset", 32'(m0), 32'h0);
      chk("R1 12-bit code after mid-frame reset", 32'(c1), 32'h0);
      frame_n = 1'b1;
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      e0_code = '0; e0_mode = '0; e1_code = '0; e1_mode = '0;
      send_frame(32'h0000_4321, 24, 1'b0, 1'b0);
      model(32'h0000_4321, 24, 1'b0);
      chk("R2 code after reset and frame", 32'(c0), 32'(e0_code));
      chk("R3 12-bit code after reset and frame", 32'(c1), 32'(e1_code));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule